// File: doc/BRIEF.md
# Store-to-Load Forwarding Search Unit

This block decides where an issued load gets its bytes. It holds a small circular queue of stores that are waiting to retire. When a load arrives with its address, byte size, load-linked flag, ordering flag and its position in the store queue, the block walks that queue from the youngest older store toward the head, one entry per clock. For each store it decides whether the load is untouched, fully covered, or only partly covered.

The outcome comes back on a one-cycle done pulse:
- A fully covering store supplies the load bytes, shifted by the address difference.
- A partial overlap asks the pipeline to reschedule the load, and names the store that blocked it.
- If no store overlaps, the load is sent on to memory.
- A strictly ordered load that is not yet the oldest committing load is turned away at once, without any search.

Stores enter at the tail through the insert port and leave from the head through the retire port. The store queue is expected to hold still while a search is running.

The controller has two states. In `ST_IDLE` it accepts a load. The load is either rejected (transition *reject*), finished at once because there is no older store (transition *no_older*), or sent to `ST_SCAN` (transition *start*). In `ST_SCAN` it examines the entry under its pointer. It returns to `ST_IDLE` on a full match (*forward*), on a partial match (*retry*), or after the head entry has been passed over (*exhausted*). Otherwise it stays in `ST_SCAN` and steps the pointer back by one, wrapping from 0 to DEPTH-1 (*step*).

Top module: `stlf_search_unit`

## Requirements
- R1: After reset `ld_done`, `ld_busy`, `ld_lock_rec` and `sq_full` are 0, and the store queue is empty.
- R2: `sq_push` writes a store at the tail and `sq_pop` retires the head. `sq_full` is 1 while DEPTH stores are held. A push while full is ignored, and so is a pop while empty.
- R3: A load with `ld_strict`=1 that lacks either `ld_lq_head` or `ld_at_commit` finishes one cycle after it is accepted. It returns outcome 2'b11, raises `ld_resched`, and examines no store. With both flags set, it is searched like any other load.
- R4: A store whose size is 0, whose strict flag is set, or whose maintenance flag is set is passed over during the search.
- R5: If `ld_llsc`=0, the store is not atomic, its mask is full, and store_start <= load_start with load_end <= store_end (end = start + size), then the outcome is 2'b01. In that case `ld_fwd_data` byte i (i < load size) equals store byte (load_addr - store_addr + i), and the bytes above the load size are 0.
- R6: A forwarding store marked all-zero yields all-zero forwarded data, whatever its data field holds.
- R7: A store that satisfies the containment of R5 but has `sq_mask_full`=0 gives outcome 2'b10.
- R8: For a normal load, the outcome is 2'b10 if any of these holds: (load_start >= store_start and load_start < store_end), or (load_end <= store_end and load_end > store_start), or (load_start < store_end and load_end > store_start). In that case `ld_resched`=1 and `ld_blk_idx`/`ld_blk_seq` give the blocking store's queue index and sequence number.
- R9: When the load is load-linked or the store is atomic, the outcome is 2'b10 whenever (load_start >= store_start or load_end > store_start) and (load_end <= store_end or load_start < store_end). Such a pair never forwards.
- R10: The search starts at `ld_sq_pos` and moves toward older stores, ending at the first full or partial match. With k stores examined, `ld_done` is high in cycle k+1 after the accepting edge.
- R11: If `ld_has_older`=0, or no examined store matches, the outcome is 2'b00 and `ld_resched`=0.
- R12: A load-linked load that is accepted and not rejected pulses `ld_lock_rec` for one cycle right after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sq_push | input | 1 | Insert a store at the tail |
| sq_addr | input | ADDR_W | Store start address |
| sq_size | input | SIZE_W | Store size in bytes |
| sq_data | input | DATA_BYTES*8 | Store data, byte 0 in the low bits |
| sq_mask_full | input | 1 | All bytes of the store are enabled |
| sq_strict | input | 1 | Store is strictly ordered |
| sq_cmo | input | 1 | Store is a cache-maintenance operation |
| sq_atomic | input | 1 | Store is atomic |
| sq_zero | input | 1 | Store carries no data and writes zeros |
| sq_seq | input | SEQ_W | Store sequence number |
| sq_pop | input | 1 | Retire the head store |
| sq_full | output | 1 | Queue holds DEPTH stores |
| ld_valid | input | 1 | Load request, taken while idle |
| ld_addr | input | ADDR_W | Load start address |
| ld_size | input | SIZE_W | Load size in bytes (1..DATA_BYTES) |
| ld_llsc | input | 1 | Load-linked load |
| ld_strict | input | 1 | Strictly ordered load |
| ld_lq_head | input | 1 | Load is at the load-queue head |
| ld_at_commit | input | 1 | Load has reached commit |
| ld_has_older | input | 1 | At least one older store is queued |
| ld_sq_pos | input | IDX_W | Queue index of the youngest older store |
| ld_busy | output | 1 | Search in progress |
| ld_done | output | 1 | One-cycle outcome strobe |
| ld_outcome | output | 2 | 00 memory, 01 forwarded, 10 retry, 11 rejected |
| ld_fwd_data | output | DATA_BYTES*8 | Forwarded load bytes |
| ld_resched | output | 1 | Load must be reissued (clears issued and address-valid) |
| ld_blk_idx | output | IDX_W | Index of the blocking store |
| ld_blk_seq | output | SEQ_W | Sequence number of the blocking store |
| ld_lock_rec | output | 1 | Lock-read recorded for a load-linked load |

## Verification
The outcome of a rejected load, or of one with no older store, is due on the first sample after the accepting edge. A searched load reports one cycle later for each store it examines. The bench samples on the falling edge and counts those falling edges from acceptance. It checks the count against the number of entries its own model expects the walk to visit, so a design that is one cycle early or late is caught. The lock-read strobe is sampled on the first falling edge after acceptance, which is the only cycle in which it may be high.

// File: rtl/stlf_pkg.sv
package stlf_pkg;

    typedef enum logic [1:0] {
        OUT_MEM    = 2'b00,
        OUT_FWD    = 2'b01,
        OUT_RETRY  = 2'b10,
        OUT_REJECT = 2'b11
    } outcome_e;

    typedef enum logic [1:0] {
        COV_SKIP = 2'b00,
        COV_NONE = 2'b01,
        COV_PART = 2'b10,
        COV_FULL = 2'b11
    } cover_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } state_e;

endpackage

// File: rtl/stlf_sq_ring.sv
module stlf_sq_ring #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 12,
    parameter int SIZE_W = 4,
    parameter int DATA_W = 64,
    parameter int SEQ_W  = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [SIZE_W-1:0] push_size,
    input  logic [DATA_W-1:0] push_data,
    input  logic              push_mask_full,
    input  logic              push_strict,
    input  logic              push_cmo,
    input  logic              push_atomic,
    input  logic              push_zero,
    input  logic [SEQ_W-1:0]  push_seq,
    input  logic              pop,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [SIZE_W-1:0] rd_size,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_mask_full,
    output logic              rd_strict,
    output logic              rd_cmo,
    output logic              rd_atomic,
    output logic              rd_zero,
    output logic [SEQ_W-1:0]  rd_seq,
    output logic [IDX_W-1:0]  head_idx,
    output logic              full
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] MAX_CNT  = CNT_W'(DEPTH);

    logic [ADDR_W-1:0] e_addr   [DEPTH];
    logic [SIZE_W-1:0] e_size   [DEPTH];
    logic [DATA_W-1:0] e_data   [DEPTH];
    logic [SEQ_W-1:0]  e_seq    [DEPTH];
    logic [DEPTH-1:0]  e_mask_full, e_strict, e_cmo, e_atomic, e_zero;

    logic [IDX_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] count_q;
    logic             do_push, do_pop;

    assign full    = (count_q == MAX_CNT);
    assign do_push = push && !full;
    assign do_pop  = pop && (count_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (do_push) tail_q <= (tail_q == LAST_IDX) ? '0 : tail_q + 1'b1;
            if (do_pop)  head_q <= (head_q == LAST_IDX) ? '0 : head_q + 1'b1;
            if (do_push && !do_pop)      count_q <= count_q + 1'b1;
            else if (do_pop && !do_push) count_q <= count_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            e_addr[tail_q]      <= push_addr;
            e_size[tail_q]      <= push_size;
            e_data[tail_q]      <= push_data;
            e_seq[tail_q]       <= push_seq;
            e_mask_full[tail_q] <= push_mask_full;
            e_strict[tail_q]    <= push_strict;
            e_cmo[tail_q]       <= push_cmo;
            e_atomic[tail_q]    <= push_atomic;
            e_zero[tail_q]      <= push_zero;
        end
    end

    assign rd_addr      = e_addr[rd_idx];
    assign rd_size      = e_size[rd_idx];
    assign rd_data      = e_data[rd_idx];
    assign rd_seq       = e_seq[rd_idx];
    assign rd_mask_full = e_mask_full[rd_idx];
    assign rd_strict    = e_strict[rd_idx];
    assign rd_cmo       = e_cmo[rd_idx];
    assign rd_atomic    = e_atomic[rd_idx];
    assign rd_zero      = e_zero[rd_idx];
    assign head_idx     = head_q;

    // R2: occupancy never exceeds the ring size
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= MAX_CNT);

    // R2: a pop on an empty ring leaves it empty
    assert_pop_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && count_q == '0) |=> (count_q == '0));

    // R2: a push on a full ring leaves the tail where it was
    assert_push_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && full) |=> $stable(tail_q));

endmodule

// File: rtl/stlf_cover_class.sv
module stlf_cover_class
    import stlf_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SIZE_W = 4
) (
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [SIZE_W-1:0] ld_size,
    input  logic              ld_llsc,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [SIZE_W-1:0] st_size,
    input  logic              st_mask_full,
    input  logic              st_strict,
    input  logic              st_cmo,
    input  logic              st_atomic,
    output cover_e            cls
);

    localparam int EW = ADDR_W + 1;

    logic [EW-1:0] lo_ld, hi_ld, lo_st, hi_st;
    logic lower_in, upper_in, lo_part, hi_part;
    logic skip, full_ok, part_plain, part_wide;

    // widened by one bit so an end address past the top does not wrap
    assign lo_ld = {1'b0, ld_addr};
    assign hi_ld = lo_ld + EW'(ld_size);
    assign lo_st = {1'b0, st_addr};
    assign hi_st = lo_st + EW'(st_size);

    assign lower_in = (lo_ld >= lo_st);
    assign upper_in = (hi_ld <= hi_st);
    assign lo_part  = (lo_ld <  hi_st);
    assign hi_part  = (hi_ld >  lo_st);

    assign skip       = (st_size == '0) || st_strict || st_cmo;
    assign full_ok    = lower_in && upper_in && !st_atomic && !ld_llsc;
    assign part_plain = !ld_llsc &&
                        ((lower_in && lo_part) || (upper_in && hi_part) || (lo_part && hi_part));
    assign part_wide  = (ld_llsc || st_atomic) &&
                        (lower_in || hi_part) && (upper_in || lo_part);

    always_comb begin
        if (skip)                         cls = COV_SKIP;
        else if (full_ok)                 cls = st_mask_full ? COV_FULL : COV_PART;
        else if (part_plain || part_wide) cls = COV_PART;
        else                              cls = COV_NONE;
    end

endmodule

// File: rtl/stlf_byte_pick.sv
module stlf_byte_pick #(
    parameter int DATA_BYTES = 8,
    parameter int SIZE_W     = 4,
    localparam int OFF_W     = $clog2(DATA_BYTES),
    localparam int DATA_W    = DATA_BYTES * 8
) (
    input  logic [DATA_W-1:0] st_data,
    input  logic [OFF_W-1:0]  off,
    input  logic [SIZE_W-1:0] ld_size,
    input  logic              zero,
    output logic [DATA_W-1:0] pick
);

    logic [7:0] src_byte [DATA_BYTES];

    for (genvar j = 0; j < DATA_BYTES; j++) begin : g_src
        assign src_byte[j] = st_data[j*8 +: 8];
    end

    for (genvar i = 0; i < DATA_BYTES; i++) begin : g_dst
        logic [OFF_W:0] src;
        logic [7:0]     b;
        assign src = {1'b0, off} + (OFF_W + 1)'(i);
        always_comb begin
            if (zero || (SIZE_W'(i) >= ld_size) || (src >= (OFF_W + 1)'(DATA_BYTES)))
                b = 8'h00;
            else
                b = src_byte[src[OFF_W-1:0]];
        end
        assign pick[i*8 +: 8] = b;
    end

endmodule

// File: rtl/stlf_scan_fsm.sv
module stlf_scan_fsm
    import stlf_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 12,
    parameter int SIZE_W = 4,
    parameter int DATA_W = 64,
    parameter int SEQ_W  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [SIZE_W-1:0] ld_size,
    input  logic              ld_llsc,
    input  logic              ld_strict,
    input  logic              ld_lq_head,
    input  logic              ld_at_commit,
    input  logic              ld_has_older,
    input  logic [IDX_W-1:0]  ld_sq_pos,
    input  logic [IDX_W-1:0]  head_idx,
    input  cover_e            cls,
    input  logic [DATA_W-1:0] pick_data,
    input  logic [SEQ_W-1:0]  rd_seq,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [SIZE_W-1:0] cur_size,
    output logic              cur_llsc,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              busy,
    output logic              done,
    output outcome_e          outcome,
    output logic [DATA_W-1:0] fwd_data,
    output logic              resched,
    output logic [IDX_W-1:0]  blk_idx,
    output logic [SEQ_W-1:0]  blk_seq,
    output logic              lock_rec
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    state_e            state_q, state_n;
    logic [IDX_W-1:0]  ptr_q, ptr_n;
    logic              capture;
    logic              done_n, resched_n, lock_n;
    outcome_e          outcome_n;
    logic [DATA_W-1:0] data_n;
    logic [IDX_W-1:0]  bidx_n;
    logic [SEQ_W-1:0]  bseq_n;

    // next state and next outputs
    always_comb begin
        state_n   = state_q;
        ptr_n     = ptr_q;
        capture   = 1'b0;
        done_n    = 1'b0;
        resched_n = 1'b0;
        lock_n    = 1'b0;
        outcome_n = outcome;
        data_n    = fwd_data;
        bidx_n    = blk_idx;
        bseq_n    = blk_seq;
        unique case (state_q)
            ST_IDLE: begin
                if (ld_valid) begin
                    if (ld_strict && !(ld_lq_head && ld_at_commit)) begin
                        // transition: reject
                        done_n    = 1'b1;
                        resched_n = 1'b1;
                        outcome_n = OUT_REJECT;
                        data_n    = '0;
                    end else begin
                        capture = 1'b1;
                        lock_n  = ld_llsc;
                        if (!ld_has_older) begin
                            // transition: no_older
                            done_n    = 1'b1;
                            outcome_n = OUT_MEM;
                            data_n    = '0;
                        end else begin
                            // transition: start
                            state_n = ST_SCAN;
                            ptr_n   = ld_sq_pos;
                        end
                    end
                end
            end
            ST_SCAN: begin
                unique case (cls)
                    COV_FULL: begin
                        // transition: forward
                        state_n   = ST_IDLE;
                        done_n    = 1'b1;
                        outcome_n = OUT_FWD;
                        data_n    = pick_data;
                    end
                    COV_PART: begin
                        // transition: retry
                        state_n   = ST_IDLE;
                        done_n    = 1'b1;
                        resched_n = 1'b1;
                        outcome_n = OUT_RETRY;
                        data_n    = '0;
                        bidx_n    = ptr_q;
                        bseq_n    = rd_seq;
                    end
                    COV_SKIP, COV_NONE: begin
                        if (ptr_q == head_idx) begin
                            // transition: exhausted
                            state_n   = ST_IDLE;
                            done_n    = 1'b1;
                            outcome_n = OUT_MEM;
                            data_n    = '0;
                        end else begin
                            // transition: step
                            ptr_n = (ptr_q == '0) ? LAST_IDX : ptr_q - 1'b1;
                        end
                    end
                endcase
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            ptr_q    <= '0;
            cur_addr <= '0;
            cur_size <= '0;
            cur_llsc <= 1'b0;
        end else begin
            state_q <= state_n;
            ptr_q   <= ptr_n;
            if (capture) begin
                cur_addr <= ld_addr;
                cur_size <= ld_size;
                cur_llsc <= ld_llsc;
            end
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done     <= 1'b0;
            resched  <= 1'b0;
            lock_rec <= 1'b0;
            outcome  <= OUT_MEM;
            fwd_data <= '0;
            blk_idx  <= '0;
            blk_seq  <= '0;
        end else begin
            done     <= done_n;
            resched  <= resched_n;
            lock_rec <= lock_n;
            outcome  <= outcome_n;
            fwd_data <= data_n;
            blk_idx  <= bidx_n;
            blk_seq  <= bseq_n;
        end
    end

    assign busy   = (state_q == ST_SCAN);
    assign rd_idx = ptr_q;

    // R5: a full match reported by the classifier ends the walk with a forward
    assert_full_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && cls == COV_FULL) |=> (done && outcome == OUT_FWD));

    // R8: a partial match ends the walk with a retry naming that entry
    assert_part_retry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && cls == COV_PART) |=>
        (done && outcome == OUT_RETRY && resched && blk_idx == $past(ptr_q)));

    // R3: a rejected load never passed through the scan state
    assert_reject_noscan_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && outcome == OUT_REJECT) |-> ($past(state_q) == ST_IDLE));

    // R9: a load-linked load is never classified as fully covered
    assert_llsc_no_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && cur_llsc) |-> (cls != COV_FULL));

    // R10: the outcome strobe only appears once the walk has stopped
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state_q == ST_IDLE));

    // R12: the lock strobe follows an accepted load-linked request
    assert_lock_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        lock_rec |-> ($past(ld_valid) && $past(ld_llsc) && $past(state_q) == ST_IDLE));

endmodule

// File: rtl/stlf_search_unit.sv
module stlf_search_unit
    import stlf_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int ADDR_W     = 12,
    parameter int DATA_BYTES = 8,
    parameter int SEQ_W      = 8,
    localparam int SIZE_W    = $clog2(DATA_BYTES + 1),
    localparam int DATA_W    = DATA_BYTES * 8,
    localparam int IDX_W     = $clog2(DEPTH),
    localparam int OFF_W     = $clog2(DATA_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sq_push,
    input  logic [ADDR_W-1:0] sq_addr,
    input  logic [SIZE_W-1:0] sq_size,
    input  logic [DATA_W-1:0] sq_data,
    input  logic              sq_mask_full,
    input  logic              sq_strict,
    input  logic              sq_cmo,
    input  logic              sq_atomic,
    input  logic              sq_zero,
    input  logic [SEQ_W-1:0]  sq_seq,
    input  logic              sq_pop,
    output logic              sq_full,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [SIZE_W-1:0] ld_size,
    input  logic              ld_llsc,
    input  logic              ld_strict,
    input  logic              ld_lq_head,
    input  logic              ld_at_commit,
    input  logic              ld_has_older,
    input  logic [IDX_W-1:0]  ld_sq_pos,
    output logic              ld_busy,
    output logic              ld_done,
    output logic [1:0]        ld_outcome,
    output logic [DATA_W-1:0] ld_fwd_data,
    output logic              ld_resched,
    output logic [IDX_W-1:0]  ld_blk_idx,
    output logic [SEQ_W-1:0]  ld_blk_seq,
    output logic              ld_lock_rec
);

    logic [ADDR_W-1:0] rd_addr, cur_addr;
    logic [SIZE_W-1:0] rd_size, cur_size;
    logic [DATA_W-1:0] rd_data, pick_data;
    logic [SEQ_W-1:0]  rd_seq;
    logic              rd_mask_full, rd_strict, rd_cmo, rd_atomic, rd_zero;
    logic [IDX_W-1:0]  rd_idx, head_idx;
    logic              cur_llsc;
    logic [OFF_W-1:0]  pick_off;
    cover_e            cls;
    outcome_e          outcome;

    stlf_sq_ring #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W), .SEQ_W(SEQ_W)
    ) ring_i (
        .clk(clk), .rst_n(rst_n),
        .push(sq_push), .push_addr(sq_addr), .push_size(sq_size), .push_data(sq_data),
        .push_mask_full(sq_mask_full), .push_strict(sq_strict), .push_cmo(sq_cmo),
        .push_atomic(sq_atomic), .push_zero(sq_zero), .push_seq(sq_seq),
        .pop(sq_pop), .rd_idx(rd_idx),
        .rd_addr(rd_addr), .rd_size(rd_size), .rd_data(rd_data),
        .rd_mask_full(rd_mask_full), .rd_strict(rd_strict), .rd_cmo(rd_cmo),
        .rd_atomic(rd_atomic), .rd_zero(rd_zero), .rd_seq(rd_seq),
        .head_idx(head_idx), .full(sq_full)
    );

    stlf_cover_class #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) class_i (
        .ld_addr(cur_addr), .ld_size(cur_size), .ld_llsc(cur_llsc),
        .st_addr(rd_addr), .st_size(rd_size), .st_mask_full(rd_mask_full),
        .st_strict(rd_strict), .st_cmo(rd_cmo), .st_atomic(rd_atomic),
        .cls(cls)
    );

    assign pick_off = OFF_W'(cur_addr - rd_addr);

    stlf_byte_pick #(.DATA_BYTES(DATA_BYTES), .SIZE_W(SIZE_W)) pick_i (
        .st_data(rd_data), .off(pick_off), .ld_size(cur_size), .zero(rd_zero),
        .pick(pick_data)
    );

    stlf_scan_fsm #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W), .SEQ_W(SEQ_W)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_size(ld_size), .ld_llsc(ld_llsc),
        .ld_strict(ld_strict), .ld_lq_head(ld_lq_head), .ld_at_commit(ld_at_commit),
        .ld_has_older(ld_has_older), .ld_sq_pos(ld_sq_pos),
        .head_idx(head_idx), .cls(cls), .pick_data(pick_data), .rd_seq(rd_seq),
        .cur_addr(cur_addr), .cur_size(cur_size), .cur_llsc(cur_llsc), .rd_idx(rd_idx),
        .busy(ld_busy), .done(ld_done), .outcome(outcome), .fwd_data(ld_fwd_data),
        .resched(ld_resched), .blk_idx(ld_blk_idx), .blk_seq(ld_blk_seq),
        .lock_rec(ld_lock_rec)
    );

    assign ld_outcome = outcome;

endmodule

// File: tb/stlf_search_unit_tb_top.sv
`timescale 1ns/1ps
module stlf_search_unit_tb_top;

    localparam int DEPTH = 8;
    localparam int AW    = 12;
    localparam int NB    = 8;
    localparam int SW    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          sq_push = 0, sq_mask_full = 1, sq_strict = 0, sq_cmo = 0;
    logic          sq_atomic = 0, sq_zero = 0, sq_pop = 0;
    logic [AW-1:0] sq_addr = '0;
    logic [3:0]    sq_size = '0;
    logic [63:0]   sq_data = '0;
    logic [SW-1:0] sq_seq = '0;
    logic          sq_full;
    logic          ld_valid = 0, ld_llsc = 0, ld_strict = 0, ld_lq_head = 0;
    logic          ld_at_commit = 0, ld_has_older = 0;
    logic [AW-1:0] ld_addr = '0;
    logic [3:0]    ld_size = '0;
    logic [2:0]    ld_sq_pos = '0;
    logic          ld_busy, ld_done, ld_resched, ld_lock_rec;
    logic [1:0]    ld_outcome;
    logic [63:0]   ld_fwd_data;
    logic [2:0]    ld_blk_idx;
    logic [SW-1:0] ld_blk_seq;

    stlf_search_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .sq_push(sq_push), .sq_addr(sq_addr), .sq_size(sq_size), .sq_data(sq_data),
        .sq_mask_full(sq_mask_full), .sq_strict(sq_strict), .sq_cmo(sq_cmo),
        .sq_atomic(sq_atomic), .sq_zero(sq_zero), .sq_seq(sq_seq), .sq_pop(sq_pop),
        .sq_full(sq_full),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_size(ld_size), .ld_llsc(ld_llsc),
        .ld_strict(ld_strict), .ld_lq_head(ld_lq_head), .ld_at_commit(ld_at_commit),
        .ld_has_older(ld_has_older), .ld_sq_pos(ld_sq_pos),
        .ld_busy(ld_busy), .ld_done(ld_done), .ld_outcome(ld_outcome),
        .ld_fwd_data(ld_fwd_data), .ld_resched(ld_resched), .ld_blk_idx(ld_blk_idx),
        .ld_blk_seq(ld_blk_seq), .ld_lock_rec(ld_lock_rec)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // bench-side model of the store queue
    int          m_addr [DEPTH];
    int          m_size [DEPTH];
    logic [63:0] m_data [DEPTH];
    int          m_seq  [DEPTH];
    bit          m_mask [DEPTH], m_strict [DEPTH], m_cmo [DEPTH], m_atomic [DEPTH], m_zero [DEPTH];
    int          m_head = 0, m_tail = 0, m_cnt = 0, seq_ctr = 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_store(input int a, input int s, input logic [63:0] d, input bit mf,
                              input bit st, input bit cm, input bit at, input bit z);
        @(negedge clk);
        sq_push = 1; sq_addr = AW'(a); sq_size = 4'(s); sq_data = d; sq_mask_full = mf;
        sq_strict = st; sq_cmo = cm; sq_atomic = at; sq_zero = z; sq_seq = SW'(seq_ctr);
        if (m_cnt < DEPTH) begin
            m_addr[m_tail] = a; m_size[m_tail] = s; m_data[m_tail] = d; m_mask[m_tail] = mf;
            m_strict[m_tail] = st; m_cmo[m_tail] = cm; m_atomic[m_tail] = at;
            m_zero[m_tail] = z; m_seq[m_tail] = seq_ctr & 8'hFF;
            m_tail = (m_tail + 1) % DEPTH; m_cnt++;
        end
        seq_ctr++;
        @(posedge clk);
        #1 sq_push = 0;
    endtask

    task automatic pop_store();
        @(negedge clk);
        sq_pop = 1;
        if (m_cnt > 0) begin m_head = (m_head + 1) % DEPTH; m_cnt--; end
        @(posedge clk);
        #1 sq_pop = 0;
    endtask

    // 0 skip, 1 none, 2 partial, 3 full
    function automatic int classify(input int la, input int ls, input bit llsc, input int i);
        int le, sa, se;
        bit lo_in, up_in, lo_p, hi_p, ovl;
        if (m_size[i] == 0 || m_strict[i] || m_cmo[i]) return 0;
        le = la + ls; sa = m_addr[i]; se = sa + m_size[i];
        lo_in = la >= sa; up_in = le <= se; lo_p = la < se; hi_p = le > sa;
        if (lo_in && up_in && !m_atomic[i] && !llsc) return m_mask[i] ? 3 : 2;
        if (!llsc && ((lo_in && lo_p) || (up_in && hi_p) || (lo_p && hi_p))) return 2;
        if ((llsc || m_atomic[i]) && (lo_in || hi_p) && (up_in || lo_p)) return 2;
        return 1;
    endfunction

    task automatic run_load(input string req, input int la, input int ls, input bit llsc,
                            input bit strict, input bit lqh, input bit atc,
                            input bit older, input int pos);
        int exp_out, exp_lat, exp_idx, exp_seq, lat, p, c;
        logic [63:0] exp_data;
        bit lock_seen, exp_lock;
        exp_data = '0; exp_idx = -1; exp_seq = 0;
        exp_lock = 0;
        if (strict && !(lqh && atc)) begin
            exp_out = 3; exp_lat = 1;
        end else begin
            exp_lock = llsc;
            exp_out = 0; exp_lat = 1;
            if (older) begin
                p = pos;
                forever begin
                    exp_lat++;
                    c = classify(la, ls, llsc, p);
                    if (c == 3) begin
                        exp_out = 1;
                        for (int k = 0; k < ls; k++)
                            exp_data[k*8 +: 8] = m_zero[p] ? 8'h00
                                                 : m_data[p][(la - m_addr[p] + k)*8 +: 8];
                        break;
                    end
                    if (c == 2) begin exp_out = 2; exp_idx = p; exp_seq = m_seq[p]; break; end
                    if (p == m_head) break;
                    p = (p == 0) ? DEPTH - 1 : p - 1;
                end
            end
        end
        @(negedge clk);
        ld_valid = 1; ld_addr = AW'(la); ld_size = 4'(ls); ld_llsc = llsc; ld_strict = strict;
        ld_lq_head = lqh; ld_at_commit = atc; ld_has_older = older; ld_sq_pos = 3'(pos);
        @(posedge clk);
        @(negedge clk);
        ld_valid = 0;
        lock_seen = ld_lock_rec;
        lat = 1;
        while (!ld_done && lat < 40) begin @(negedge clk); lat++; end
        check(lat == exp_lat, req, "latency", 64'(lat), 64'(exp_lat));
        check(ld_outcome == 2'(exp_out), req, "outcome", 64'(ld_outcome), 64'(exp_out));
        check(ld_resched == (exp_out >= 2), req, "resched", 64'(ld_resched), 64'(exp_out >= 2));
        check(lock_seen == exp_lock, "R12", "lock strobe", 64'(lock_seen), 64'(exp_lock));
        if (exp_out == 1)
            check(ld_fwd_data == exp_data, req, "forward data", ld_fwd_data, exp_data);
        if (exp_out == 2) begin
            check(ld_blk_idx == 3'(exp_idx), req, "blocking index", 64'(ld_blk_idx), 64'(exp_idx));
            check(ld_blk_seq == SW'(exp_seq), req, "blocking seq", 64'(ld_blk_seq), 64'(exp_seq));
        end
    endtask

    function automatic int youngest();
        return (m_tail == 0) ? DEPTH - 1 : m_tail - 1;
    endfunction

    task automatic drain();
        while (m_cnt > 0) pop_store();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int unused;
        unused = $urandom(32'h5A17);
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(ld_done == 0 && ld_busy == 0 && ld_lock_rec == 0, "R1", "idle outputs",
              {61'd0, ld_done, ld_busy, ld_lock_rec}, 64'd0);
        check(sq_full == 0, "R1", "queue not full", 64'(sq_full), 64'd0);
        run_load("R1", 16, 4, 0, 0, 0, 0, 0, 0);

        // R11 no older store
        run_load("R11", 4, 2, 0, 0, 0, 0, 0, 0);

        // R5 shifted forwarding
        push_store(16, 8, 64'h8877_6655_4433_2211, 1, 0, 0, 0, 0);
        run_load("R5", 19, 2, 0, 0, 0, 0, 1, youngest());
        run_load("R5", 16, 8, 0, 0, 0, 0, 1, youngest());
        // R3 strict loads
        run_load("R3", 16, 4, 0, 1, 1, 0, 1, youngest());
        run_load("R3", 16, 4, 0, 1, 0, 1, 1, youngest());
        run_load("R3", 17, 4, 0, 1, 1, 1, 1, youngest());
        // R8 partial overlap on each side
        run_load("R8", 14, 4, 0, 0, 0, 0, 1, youngest());
        run_load("R8", 22, 4, 0, 0, 0, 0, 1, youngest());
        // R11 adjacent but not overlapping
        run_load("R11", 24, 4, 0, 0, 0, 0, 1, youngest());
        run_load("R11", 12, 4, 0, 0, 0, 0, 1, youngest());
        // R9 load-linked inside a store, and R12 lock strobe
        run_load("R9", 17, 2, 1, 0, 0, 0, 1, youngest());
        run_load("R12", 40, 2, 1, 0, 0, 0, 1, youngest());
        // R6 zero store and R7 masked store, younger than the first
        push_store(32, 4, 64'hDEAD_BEEF_CAFE_F00D, 1, 0, 0, 0, 1);
        run_load("R6", 33, 2, 0, 0, 0, 0, 1, youngest());
        push_store(48, 8, 64'h1122_3344_5566_7788, 0, 0, 0, 0, 0);
        run_load("R7", 48, 4, 0, 0, 0, 0, 1, youngest());
        // R10 walk reaches the oldest store past two non-matching ones
        run_load("R10", 18, 2, 0, 0, 0, 0, 1, youngest());
        // R9 atomic store with a normal load inside it
        push_store(64, 8, 64'h0, 1, 0, 0, 1, 0);
        run_load("R9", 66, 2, 0, 0, 0, 0, 1, youngest());
        // R4 skipped stores covering the same bytes as an older forwarder
        push_store(16, 0, 64'h0, 1, 0, 0, 0, 0);
        push_store(16, 8, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 0, 0, 0);
        push_store(16, 8, 64'hEEEE_EEEE_EEEE_EEEE, 1, 0, 1, 0, 0);
        run_load("R4", 20, 4, 0, 0, 0, 0, 1, youngest());
        // R2 fill, ignored push, full flag
        push_store(80, 8, 64'h0102_0304_0506_0708, 1, 0, 0, 0, 0);
        @(negedge clk);
        check(sq_full == 1, "R2", "full at depth", 64'(sq_full), 64'd1);
        push_store(96, 8, 64'h9999_9999_9999_9999, 1, 0, 0, 0, 0);
        run_load("R2", 96, 4, 0, 0, 0, 0, 1, youngest());
        pop_store();
        @(negedge clk);
        check(sq_full == 0, "R2", "not full after pop", 64'(sq_full), 64'd0);
        drain();
        pop_store();
        push_store(200, 8, 64'hA1A2_A3A4_A5A6_A7A8, 1, 0, 0, 0, 0);
        run_load("R2", 204, 4, 0, 0, 0, 0, 1, youngest());
        // R10 younger match wins over an older one
        push_store(200, 8, 64'hB1B2_B3B4_B5B6_B7B8, 1, 0, 0, 0, 0);
        run_load("R10", 202, 2, 0, 0, 0, 0, 1, youngest());
        drain();

        // constrained random mix
        for (int it = 0; it < 400; it++) begin
            int r, pos, k;
            r = $urandom_range(0, 9);
            if (r < 4 && m_cnt < DEPTH) begin
                push_store($urandom_range(0, 23),
                           ($urandom_range(0, 9) == 0) ? 0 : $urandom_range(1, 8),
                           {$urandom, $urandom},
                           $urandom_range(0, 9) != 0,
                           $urandom_range(0, 19) == 0,
                           $urandom_range(0, 19) == 0,
                           $urandom_range(0, 9) == 0,
                           $urandom_range(0, 9) == 0);
            end else if (r < 6 && m_cnt > 0) begin
                pop_store();
            end else begin
                k = (m_cnt > 0) ? $urandom_range(0, m_cnt - 1) : 0;
                pos = (m_head + k) % DEPTH;
                run_load("R10", $urandom_range(0, 23), $urandom_range(1, 8),
                         $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
                         $urandom_range(0, 1), $urandom_range(0, 1), m_cnt > 0, pos);
            end
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule